// File: doc/BRIEF.md
# Self-Timed Byte-Wide Nonvolatile Memory Model

This block is a clock-synchronous stand-in for a 2K x 8 parallel nonvolatile memory. It exposes an SRAM-like strobe interface: active-low chip select, output enable and write enable, an 11-bit address, an 8-bit data input and an 8-bit data output that comes with its own drive-enable flag. Any board-level tri-state buffer is outside the block. All strobes, the address and the data input pass through a synchronizer of `SYNC_STAGES` flops. The stored byte reaches the output one registered stage after that.

A byte write is framed by the strobes. The window opens in the first synchronized cycle in which both chip select and write enable are low while output enable is high. The address is taken in that cycle. The window closes in the first cycle in which either strobe is high again, and the data is taken in that cycle. The block then runs a self-timed internal cycle of `WRITE_CYC` clocks. In the first half, a staging byte is set to the erased value. In the second half, it holds the new value. The byte is committed to the array at the end. While the cycle runs, the ready flag is low and every read returns a polling pattern.

Writes are refused during a power-on hold-off of `POR_CYC` clocks, while the low-supply input is high, and while a write cycle is already running. A 32-byte identification area overlays the top of the address space when the high-voltage ID input is high.

Top module: `pmem_emu`

## Requirements
- R1: When the synchronized chip select and output enable are low and write enable is high, `dout_en` is 1 and `dout` carries the byte stored at `addr`, three clocks after the inputs are applied (two synchronizer stages plus the output register).
- R2: Whenever the read condition of R1 does not hold, `dout_en` is 0 and `dout` is all zeros. This includes a cycle in which write enable is low.
- R3: A write window opens in the first cycle with chip select and write enable both low and output enable high, and takes the address of that cycle. It closes in the first cycle with either strobe high and takes the data of that cycle. Either strobe may be the one that pulses.
- R4: Once a window closes, `ready` goes low for exactly `WRITE_CYC` clocks. After that, the new byte is returned by reads.
- R5: While `ready` is low, a read of any address returns bit 7 inverted from the byte being written, with bits 6..0 taken from the byte currently stored at the address read.
- R6: If output enable goes low while a window is open, the window is dropped and no write takes place.
- R7: While `low_supply` is high, no window opens, and an open window is dropped.
- R8: For the first `POR_CYC` clocks after reset, no write window can open.
- R9: While a write cycle runs, strobe activity starts no new write, and the running cycle keeps its full length.
- R10: With `id_hv` high and address bits 10..5 all ones (0x7E0 to 0x7FF), reads and writes go to a separate 32-byte area indexed by address bits 4..0. The main-array bytes at those addresses are not touched.
- R11: After reset, every byte of both areas reads 0xFF, `ready` is 1 and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| id_hv | input | 1 | High-voltage ID select flag |
| low_supply | input | 1 | Low-supply flag; blocks writes |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | Output drive enable |
| ready | output | 1 | High when no internal write is running |

## Verification
A read and an internal write cycle can overlap. The bench therefore issues reads right after a write window closes, while `ready` is still low. It checks that the inverted bit 7 and the old low bits appear, and that true data appears exactly one clock after commit. A new strobe pulse can also land during a running cycle. The bench fires a second write back-to-back with the first and judges, at the ports, that the cycle length is unchanged and that the second address still reads erased. A behavioural model tracks every clock, so a boundary off by one cycle is reported.

// File: rtl/pmem_pkg.sv
// Shared types for the self-timed memory model.
// Assumes: strobes are active low; the flags are active high.
package pmem_pkg;

    // Synchronized control inputs, bundled for a single synchronizer.
    typedef struct packed {
        logic hv;
        logic low;
        logic ce_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    // Value the control synchronizer holds during reset: all strobes inactive.
    localparam strobe_t STROBE_REST = '{hv: 1'b0, low: 1'b0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

    // Phases of the internal programming sequence.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_PROG  = 2'd2
    } phase_t;

endpackage

// File: rtl/pmem_sync.sv
// Multi-flop synchronizer for a bundle of asynchronous inputs.
// Assumes: STAGES >= 2; the bundle is held stable by the driver long enough
// that the skew between bits does not matter.
module pmem_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the sampled bundle one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/pmem_por.sv
// Power-on hold-off counter: reports when writes may start.
// Assumes: POR_CYC >= 1; the count stops at the limit.
module pmem_por #(
    parameter int POR_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic por_ok
);

    localparam int             PW      = $clog2(POR_CYC + 1);
    localparam logic [PW-1:0]  POR_END = PW'(POR_CYC);

    logic [PW-1:0] cnt;

    // Count clocks since reset, saturating at the hold-off limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != POR_END) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign por_ok = (cnt == POR_END);

endmodule

// File: rtl/pmem_wcap.sv
// Write-window capture: frames one byte write from the synchronized strobes.
// The address is taken in the cycle the window opens (the later falling strobe).
// Closing happens when either strobe rises (the earlier rising strobe), and
// start is then high for one cycle; the data is taken by the caller in that cycle.
// Assumes: can_write already folds in busy, power-on and supply gating.
module pmem_wcap #(
    parameter int ADDR_W = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  pmem_pkg::strobe_t      s,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   id_hit,
    input  logic                   can_write,
    output logic                   start,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic                   wr_id
);

    logic win;
    logic opening;
    logic abort;

    // The window opens only with both strobes low, output enable high and writes allowed.
    assign opening = !win && !s.ce_n && !s.we_n && s.oe_n && can_write;
    // Output enable low or supply loss drops an open window.
    assign abort   = win && (!s.oe_n || s.low);
    // The first cycle with either strobe high ends the window with a request.
    assign start   = win && !abort && (s.ce_n || s.we_n);

    // Track the window and hold the address and area chosen when it opened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win     <= 1'b0;
            wr_addr <= '0;
            wr_id   <= 1'b0;
        end else if (opening) begin
            win     <= 1'b1;
            wr_addr <= addr;
            wr_id   <= id_hit;
        end else if (abort || start) begin
            win     <= 1'b0;
        end
    end

endmodule

// File: rtl/pmem_prog.sv
// Storage arrays and the self-timed programming sequencer.
// A request runs WRITE_CYC clocks. The first half sets a staging byte to the
// erased value; the second half loads the new value into it. The array is
// written on the last clock, so during the cycle the array still shows the old byte.
// Assumes: WRITE_CYC >= 4; ID_BYTES is a power of two and at most 2**ADDR_W;
// start is never raised while busy.
module pmem_prog #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int ID_BYTES  = 32,
    parameter int WRITE_CYC = 400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               wr_id,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_id,
    output logic               busy,
    output logic               poll_msb,
    output logic [DATA_W-1:0]  rd_byte
);

    import pmem_pkg::*;

    localparam int             DEPTH     = 1 << ADDR_W;
    localparam int             ID_W      = $clog2(ID_BYTES);
    localparam int             CW        = $clog2(WRITE_CYC);
    localparam int             ERASE_CYC = WRITE_CYC / 2;
    localparam logic [CW-1:0]  ERASE_END = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0]  PROG_END  = CW'(WRITE_CYC - 1);

    phase_t             phase;
    logic [CW-1:0]      cnt;
    logic [ADDR_W-1:0]  tgt_addr;
    logic               tgt_id;
    logic [DATA_W-1:0]  pdata;
    logic [DATA_W-1:0]  stage;
    logic               commit;

    logic [DATA_W-1:0]  main_mem [DEPTH];
    logic [DATA_W-1:0]  id_mem   [ID_BYTES];

    assign commit = (phase == PH_PROG) && (cnt == PROG_END);

    // Sequence one request through erase and program phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_id   <= 1'b0;
            pdata    <= '0;
            stage    <= '1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_ERASE;
                        cnt      <= '0;
                        tgt_addr <= wr_addr;
                        tgt_id   <= wr_id;
                        pdata    <= wr_data;
                        stage    <= '1;
                    end
                end
                PH_ERASE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == ERASE_END) begin
                        phase <= PH_PROG;
                        stage <= pdata;
                    end
                end
                PH_PROG: begin
                    if (commit) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Main array: erased on reset, written once at the end of a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) main_mem[i] <= '1;
        end else if (commit && !tgt_id) begin
            main_mem[tgt_addr] <= stage;
        end
    end

    // Identification area: same treatment, indexed by the low address bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ID_BYTES; i++) id_mem[i] <= '1;
        end else if (commit && tgt_id) begin
            id_mem[tgt_addr[ID_W-1:0]] <= stage;
        end
    end

    // Select the area being read.
    always_comb begin
        if (rd_id) rd_byte = id_mem[rd_addr[ID_W-1:0]];
        else       rd_byte = main_mem[rd_addr];
    end

    assign busy     = (phase != PH_IDLE);
    assign poll_msb = pdata[DATA_W-1];

endmodule

// File: rtl/pmem_emu.sv
// Top of the self-timed memory model. It synchronizes the pin inputs, frames
// write windows, gates them on power-on, supply and busy state, and registers
// the read data with a separate drive-enable flag.
// Assumes: the driver holds address and data stable around strobe edges for
// at least SYNC_STAGES clocks.
module pmem_emu #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int ID_BYTES    = 32,
    parameter int WRITE_CYC   = 400,
    parameter int POR_CYC     = 1000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_n,
    input  logic               oe_n,
    input  logic               we_n,
    input  logic               id_hv,
    input  logic               low_supply,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  din,
    output logic [DATA_W-1:0]  dout,
    output logic               dout_en,
    output logic               ready
);

    import pmem_pkg::*;

    localparam int ID_W   = $clog2(ID_BYTES);
    localparam int CTRL_W = $bits(strobe_t);
    localparam int BUS_W  = ADDR_W + DATA_W;

    strobe_t            raw;
    strobe_t            s;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [BUS_W-1:0]   bus_q;
    logic [ADDR_W-1:0]  s_addr;
    logic [DATA_W-1:0]  s_din;
    logic               id_hit;
    logic               busy;
    logic               por_ok;
    logic               can_write;
    logic               wr_start;
    logic [ADDR_W-1:0]  wr_addr;
    logic               wr_id;
    logic               poll_msb;
    logic [DATA_W-1:0]  rd_byte;
    logic [DATA_W-1:0]  rd_val;
    logic               rd_act;
    logic [DATA_W-1:0]  dout_q;
    logic               den_q;

    assign raw = '{hv: id_hv, low: low_supply, ce_n: ce_n, oe_n: oe_n, we_n: we_n};

    pmem_sync #(
        .W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_REST)
    ) u_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(ctrl_q)
    );

    pmem_sync #(
        .W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)
    ) u_sync_bus (
        .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_q)
    );

    assign s      = strobe_t'(ctrl_q);
    assign s_addr = bus_q[BUS_W-1:DATA_W];
    assign s_din  = bus_q[DATA_W-1:0];

    // The ID area is the top ID_BYTES addresses, and only with the high-voltage flag.
    assign id_hit    = s.hv && (&s_addr[ADDR_W-1:ID_W]);
    assign can_write = !busy && por_ok && !s.low;

    pmem_por #(.POR_CYC(POR_CYC)) u_por (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok)
    );

    pmem_wcap #(.ADDR_W(ADDR_W)) u_wcap (
        .clk(clk), .rst_n(rst_n), .s(s), .addr(s_addr), .id_hit(id_hit),
        .can_write(can_write), .start(wr_start), .wr_addr(wr_addr), .wr_id(wr_id)
    );

    pmem_prog #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_BYTES(ID_BYTES), .WRITE_CYC(WRITE_CYC)
    ) u_prog (
        .clk(clk), .rst_n(rst_n), .start(wr_start), .wr_addr(wr_addr), .wr_id(wr_id),
        .wr_data(s_din), .rd_addr(s_addr), .rd_id(id_hit), .busy(busy),
        .poll_msb(poll_msb), .rd_byte(rd_byte)
    );

    assign rd_act = !s.ce_n && !s.oe_n && s.we_n;
    // While busy, bit 7 shows the inverse of the byte being written.
    assign rd_val = busy ? {~poll_msb, rd_byte[DATA_W-2:0]} : rd_byte;

    // Register the read data and its drive flag; zero when not driving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            den_q  <= 1'b0;
        end else begin
            den_q  <= rd_act;
            dout_q <= rd_act ? rd_val : '0;
        end
    end

    assign dout    = dout_q;
    assign dout_en = den_q;
    assign ready   = !busy;

endmodule

// File: rtl/pmem_emu_chk.sv
// Protocol checker for pmem_emu, bound to every instance of it.
// Assumes: the start and por_ok nets of the top are visible to the bind.
module pmem_emu_chk #(
    parameter int WRITE_CYC = 400,
    parameter int DATA_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              dout_en,
    input logic [DATA_W-1:0] dout,
    input logic              start,
    input logic              por_ok
);

    int busy_len;

    // Count consecutive cycles with ready low.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_len <= 0;
        else if (!ready) busy_len <= busy_len + 1;
        else             busy_len <= 0;
    end

    // R2: an undriven output is all zeros.
    a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0);

    // R4: the ready flag drops only right after a write request.
    a_r4_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(start));

    // R4: ready comes back after exactly the cycle length.
    a_r4_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> busy_len == WRITE_CYC);

    // R9: no request is accepted while a cycle runs.
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ready);

    // R8: no request before the power-on hold-off ends.
    a_r8_por_gate: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> por_ok);

endmodule

bind pmem_emu pmem_emu_chk #(.WRITE_CYC(WRITE_CYC), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .dout_en(dout_en), .dout(dout),
    .start(wr_start), .por_ok(por_ok)
);

// File: tb/tb_pmem_emu.sv
`timescale 1ns/100ps
// Bench for pmem_emu: directed scenarios plus a behavioural model compared each clock.
module tb_pmem_emu;

    localparam int WC  = 16;
    localparam int POR = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, id_hv = 1'b0, low_supply = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, ready;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pmem_emu #(.WRITE_CYC(WC), .POR_CYC(POR)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .id_hv(id_hv), .low_supply(low_supply), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .ready(ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mmem [2048];
    int mid  [32];
    logic [23:0] pipe_q [$];
    int m_busy, m_cnt, m_win, m_por, m_wa, m_wid, m_wd, m_ta, m_tid, m_pd;
    int exp_en, exp_do;

    always @(posedge clk) begin
        logic [23:0] sv;
        int sa, sid, stored, okw, st;
        if (!rst_n) begin
            foreach (mmem[i]) mmem[i] = 8'hFF;
            foreach (mid[i])  mid[i]  = 8'hFF;
            pipe_q.delete();
            pipe_q.push_back(24'h380000);
            pipe_q.push_back(24'h380000);
            m_busy = 0; m_cnt = 0; m_win = 0; m_por = 0;
            exp_en = 0; exp_do = 0;
        end else begin
            sv = pipe_q.pop_front();
            pipe_q.push_back({id_hv, low_supply, ce_n, oe_n, we_n, addr, din});
            sa  = int'(sv[18:8]);
            sid = (sv[23] && sv[18:13] == 6'h3F) ? 1 : 0;
            stored = sid ? mid[sa % 32] : mmem[sa];
            exp_en = (!sv[21] && !sv[20] && sv[19]) ? 1 : 0;
            if (!exp_en)     exp_do = 0;
            else if (m_busy) exp_do = (stored & 8'h7F) | ((~m_pd) & 8'h80);
            else             exp_do = stored;
            okw = (!m_busy && m_por == POR && !sv[22]) ? 1 : 0;
            st = 0;
            if (!m_win) begin
                if (!sv[21] && !sv[19] && sv[20] && okw) begin
                    m_win = 1; m_wa = sa; m_wid = sid;
                end
            end else if (!sv[20] || sv[22]) begin
                m_win = 0;
            end else if (sv[21] || sv[19]) begin
                m_win = 0; st = 1; m_wd = int'(sv[7:0]);
            end
            if (m_busy) begin
                if (m_cnt == WC - 1) begin
                    if (m_tid) mid[m_ta % 32] = m_pd; else mmem[m_ta] = m_pd;
                    m_busy = 0;
                end else m_cnt++;
            end else if (st) begin
                m_busy = 1; m_cnt = 0; m_pd = m_wd; m_ta = m_wa; m_tid = m_wid;
            end
            if (m_por < POR) m_por++;
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 dout_en vs model", int'(dout_en), exp_en);
            chk("R1 dout vs model", int'(dout), exp_do);
            chk("R4 ready vs model", int'(ready), m_busy ? 0 : 1);
        end
    end

    // Busy-run monitor at the ports.
    int run = 0, last_len = 0;
    bit saw_busy = 0;
    always @(negedge clk) begin
        if (!ready) begin run++; saw_busy = 1; end
        else begin if (run > 0) last_len = run; run = 0; end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr_we(input int a, input int d, input bit hv);
        @(negedge clk);
        addr = 11'(a); din = 8'(d); id_hv = hv; oe_n = 1; ce_n = 0; we_n = 1;
        repeat (3) @(negedge clk);
        we_n = 0;
        repeat (4) @(negedge clk);
        we_n = 1;
        repeat (3) @(negedge clk);
        ce_n = 1; id_hv = 0;
    endtask

    task automatic rd(input int a, input bit hv, output int v, output int en);
        @(negedge clk);
        addr = 11'(a); id_hv = hv; we_n = 1; ce_n = 0; oe_n = 0;
        repeat (3) @(negedge clk);
        v = int'(dout); en = int'(dout_en);
        ce_n = 1; oe_n = 1; id_hv = 0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 1000 && !ready; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1; errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v, en;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk("R11 ready after reset", int'(ready), 1);
        chk("R11 dout_en after reset", int'(dout_en), 0);
        chk("R11 dout after reset", int'(dout), 0);

        // R8: write attempted inside the hold-off is refused
        saw_busy = 0;
        wr_we(11'h010, 8'hA5, 0);
        chk("R8 no busy during hold-off", int'(saw_busy), 0);
        repeat (POR) @(negedge clk);
        rd(11'h010, 0, v, en);
        chk("R8 byte unchanged", v, 8'hFF);
        chk("R11 erased read", en, 1);

        // R3/R4: write-enable controlled write
        wr_we(11'h123, 8'h5A, 0);
        wait_ready();
        chk("R4 busy length", last_len, WC);
        rd(11'h123, 0, v, en);
        chk("R3 written byte", v, 8'h5A);
        chk("R1 read enable", en, 1);

        // R5: polling, bit 7 of new data = 0
        wr_we(11'h123, 8'h3C, 0);
        rd(11'h123, 0, v, en);
        chk("R5 poll pattern msb low", v, 8'hDA);
        wait_ready();
        rd(11'h123, 0, v, en);
        chk("R5 true data after cycle", v, 8'h3C);

        // R5: polling, bit 7 of new data = 1
        wr_we(11'h200, 8'h81, 0);
        rd(11'h200, 0, v, en);
        chk("R5 poll pattern msb high", v, 8'h7F);
        wait_ready();

        // R9: second request during a cycle is dropped
        wr_we(11'h300, 8'h11, 0);
        wr_we(11'h301, 8'h22, 0);
        wait_ready();
        chk("R9 cycle length kept", last_len, WC);
        rd(11'h301, 0, v, en);
        chk("R9 second byte not written", v, 8'hFF);
        rd(11'h300, 0, v, en);
        chk("R9 first byte written", v, 8'h11);

        // R3: chip-select controlled, address moves before and after window opens
        @(negedge clk);
        addr = 11'h044; din = 8'h00; oe_n = 1; we_n = 0; ce_n = 1;
        repeat (2) @(negedge clk);
        addr = 11'h055;
        repeat (3) @(negedge clk);
        ce_n = 0;
        repeat (3) @(negedge clk);
        addr = 11'h056; din = 8'h6B;
        repeat (3) @(negedge clk);
        ce_n = 1;
        repeat (3) @(negedge clk);
        we_n = 1;
        wait_ready();
        rd(11'h055, 0, v, en);
        chk("R3 address from later falling strobe", v, 8'h6B);
        rd(11'h056, 0, v, en);
        chk("R3 later address not written", v, 8'hFF);
        rd(11'h044, 0, v, en);
        chk("R3 earlier address not written", v, 8'hFF);

        // R6: output enable falls inside the window
        saw_busy = 0;
        @(negedge clk);
        addr = 11'h060; din = 8'h12; oe_n = 1; ce_n = 0; we_n = 0;
        repeat (3) @(negedge clk);
        oe_n = 0;
        repeat (3) @(negedge clk);
        we_n = 1;
        repeat (3) @(negedge clk);
        ce_n = 1; oe_n = 1;
        repeat (4) @(negedge clk);
        chk("R6 no busy", int'(saw_busy), 0);
        rd(11'h060, 0, v, en);
        chk("R6 byte unchanged", v, 8'hFF);

        // R7: low supply blocks the write
        saw_busy = 0;
        @(negedge clk); low_supply = 1;
        wr_we(11'h070, 8'h34, 0);
        repeat (3) @(negedge clk);
        low_supply = 0;
        chk("R7 no busy", int'(saw_busy), 0);
        rd(11'h070, 0, v, en);
        chk("R7 byte unchanged", v, 8'hFF);

        // R10: identification area is separate from the main array
        wr_we(11'h7E5, 8'h77, 1);
        wait_ready();
        wr_we(11'h7E6, 8'h99, 0);
        wait_ready();
        rd(11'h7E5, 0, v, en);
        chk("R10 main array untouched", v, 8'hFF);
        rd(11'h7E5, 1, v, en);
        chk("R10 id byte written", v, 8'h77);
        rd(11'h7E6, 1, v, en);
        chk("R10 id byte untouched by main write", v, 8'hFF);
        rd(11'h7E6, 0, v, en);
        chk("R10 main byte written", v, 8'h99);

        // R2: quiet bus when idle and when write enable is low with output enable low
        repeat (4) @(negedge clk);
        chk("R2 idle dout_en", int'(dout_en), 0);
        chk("R2 idle dout", int'(dout), 0);
        @(negedge clk);
        addr = 11'h123; ce_n = 0; oe_n = 0; we_n = 0;
        repeat (4) @(negedge clk);
        chk("R2 no drive with write enable low", int'(dout_en), 0);
        ce_n = 1; oe_n = 1; we_n = 1;
        repeat (4) @(negedge clk);
        rd(11'h123, 0, v, en);
        chk("R2 byte unchanged by blocked strobes", v, 8'h3C);

        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule